// File: doc/BRIEF.md
# Control-Bit Composed Arithmetic Logic Unit

This block combines two equal-width operands under six independent control bits to give one result word and two status flags. There is no opcode decoder. Each operand can be cleared and then bitwise complemented. The two conditioned operands are then either summed or ANDed, and the chosen value can be complemented once more. Eighteen useful functions come out of this fixed chain when the control bits are set to the right codes, among them constants, pass-through, negation, increment, decrement, sum, difference, AND and OR.

The datapath between the operands and the result is combinational. One output register with a synchronous, active-high reset captures the result and the flags, so the block sits cleanly inside a clocked pipeline. A processor core feeds it from its register file and reads the flags to decide on branches.

Top module: `ctl_alu`

## Requirements
- R1: Control bit 5 (clear-x) forces operand x to zero before any complement of x is applied.
- R2: Control bit 4 (flip-x) bitwise complements operand x after the clear-x step.
- R3: Control bits 3 (clear-y) and 2 (flip-y) act on operand y in the same order and manner that bits 5 and 4 act on x.
- R4: When control bit 1 (select-sum) is 1, the core value is the two's-complement sum of the conditioned operands modulo 2^W, with the carry out dropped.
- R5: When control bit 1 is 0, the core value is the bitwise AND of the conditioned operands.
- R6: Control bit 0 (flip-out) bitwise complements the core value to give the result.
- R7: The zero flag is 1 exactly when every bit of the presented result is 0.
- R8: The negative flag equals the most significant bit of the presented result.
- R9: Result and flags appear one clock edge after the operands and control bits are sampled. While reset is high at an edge, the result becomes 0, the zero flag 1 and the negative flag 0.
- R10: The control codes written as bits 5..0 give these functions: 101010 gives 0, 111111 gives 1, 111010 gives -1, 001100 gives x, 110000 gives y, 001101 gives ~x, 110001 gives ~y, 001111 gives -x, 110011 gives -y, 011111 gives x+1, 110111 gives y+1, 001110 gives x-1, 110010 gives y-1, 000010 gives x+y, 010011 gives x-y, 000111 gives y-x, 000000 gives x&y, and 010101 gives x|y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | W | First operand |
| y_in | input | W | Second operand |
| ctl_in | input | 6 | Controls: bit5 clear-x, bit4 flip-x, bit3 clear-y, bit2 flip-y, bit1 select-sum, bit0 flip-out |
| res_out | output | W | Registered result |
| zr_out | output | 1 | Registered zero flag |
| ng_out | output | 1 | Registered negative flag |

## Verification
The clocked properties compare the result with the operands and controls of the previous cycle. They therefore assume that x_in, y_in and ctl_in are defined, two-state values at every sampling edge after reset. The stimulus changes them only on the falling clock edge and never leaves them undriven. Operands come from the full range of words, including 0, the most positive word, the most negative word and all ones. The flag properties then see carry drop-out, sign changes and zero results.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;

  localparam int CTL_W = 6;

  // Field order fixes the bit positions of the control word (MSB first).
  typedef struct packed {
    logic zero_x;
    logic inv_x;
    logic zero_y;
    logic inv_y;
    logic use_add;
    logic inv_out;
  } alu_ctl_t;

  localparam int N_OPND = 2;

endpackage

// File: rtl/opnd_cond.sv
module opnd_cond #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic         zero_en,
  input  logic         inv_en,
  output logic [W-1:0] cond
);

  logic [W-1:0] cleared;

  always_comb begin
    cleared = zero_en ? '0 : raw;
    cond    = inv_en ? ~cleared : cleared;
  end

  // Clearing comes first, so clear alone always gives zero (R1, R3).
  always_comb begin
    if (zero_en && !inv_en) begin
      p_clear_only_r1 : assert (cond == '0);
    end
    if (zero_en && inv_en) begin
      p_clear_then_flip_r2 : assert (&cond);
    end
  end

endmodule

// File: rtl/fn_core.sv
module fn_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_add,
  input  logic         inv_out,
  output logic [W-1:0] res
);

  logic [W-1:0] sum_v;
  logic [W-1:0] and_v;
  logic [W-1:0] pick;

  always_comb begin
    sum_v = a + b;
    and_v = a & b;
    pick  = use_add ? sum_v : and_v;
    res   = inv_out ? ~pick : pick;
  end

endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic         is_zero,
  output logic         is_neg
);

  always_comb begin
    is_zero = ~|val;
    is_neg  = val[W-1];
  end

endmodule

// File: rtl/ctl_alu.sv
module ctl_alu
  import ctl_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     x_in,
  input  logic [W-1:0]     y_in,
  input  logic [CTL_W-1:0] ctl_in,
  output logic [W-1:0]     res_out,
  output logic             zr_out,
  output logic             ng_out
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  alu_ctl_t     c;
  logic [W-1:0] raw_op  [N_OPND];
  logic [W-1:0] cond_op [N_OPND];
  logic         zero_sel[N_OPND];
  logic         inv_sel [N_OPND];
  logic [W-1:0] core_res;
  logic         core_zr;
  logic         core_ng;

  always_comb begin
    c           = alu_ctl_t'(ctl_in);
    raw_op[0]   = x_in;
    raw_op[1]   = y_in;
    zero_sel[0] = c.zero_x;
    zero_sel[1] = c.zero_y;
    inv_sel[0]  = c.inv_x;
    inv_sel[1]  = c.inv_y;
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    opnd_cond #(.W(W)) u_cond (
      .raw     (raw_op[g]),
      .zero_en (zero_sel[g]),
      .inv_en  (inv_sel[g]),
      .cond    (cond_op[g])
    );
  end

  fn_core #(.W(W)) u_core (
    .a       (cond_op[0]),
    .b       (cond_op[1]),
    .use_add (c.use_add),
    .inv_out (c.inv_out),
    .res     (core_res)
  );

  flag_gen #(.W(W)) u_flags (
    .val     (core_res),
    .is_zero (core_zr),
    .is_neg  (core_ng)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      zr_out  <= 1'b1;
      ng_out  <= 1'b0;
    end else begin
      res_out <= core_res;
      zr_out  <= core_zr;
      ng_out  <= core_ng;
    end
  end

  p_reset_state_r9 : assert property (@(posedge clk)
    rst |=> (res_out == '0 && zr_out && !ng_out));

  p_zero_flag_r7 : assert property (@(posedge clk) disable iff (rst)
    zr_out == (res_out == '0));

  p_neg_flag_r8 : assert property (@(posedge clk) disable iff (rst)
    ng_out == res_out[W-1]);

  p_const_zero_r10 : assert property (@(posedge clk) disable iff (rst)
    (ctl_in == 6'b101010) |=> (res_out == '0));

  p_const_ones_r10 : assert property (@(posedge clk) disable iff (rst)
    (ctl_in == 6'b111010) |=> (res_out == ALL_ONES));

  p_and_mode_r5 : assert property (@(posedge clk) disable iff (rst)
    (ctl_in == 6'b000000) |=> (res_out == ($past(x_in) & $past(y_in))));

  p_sum_mode_r4 : assert property (@(posedge clk) disable iff (rst)
    (ctl_in == 6'b000010) |=> (res_out == W'($past(x_in) + $past(y_in))));

  p_flip_out_r6 : assert property (@(posedge clk) disable iff (rst)
    (ctl_in == 6'b000001) |=> (res_out == ~($past(x_in) & $past(y_in))));

endmodule

// File: tb/ctl_alu_bench.sv
module ctl_alu_bench;

  localparam int  W      = 16;
  localparam time CLK_T  = 10ns;
  localparam int  N_RAND = 24;

  typedef struct {
    logic [W-1:0] res;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] y_in = '0;
  logic [5:0]   ctl_in = '0;
  logic [W-1:0] res_out;
  logic         zr_out;
  logic         ng_out;

  int   n_chk  = 0;
  int   n_bad  = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #(CLK_T/2) clk = ~clk;

  ctl_alu #(.W(W)) u_ctl_alu (
    .clk, .rst, .x_in, .y_in, .ctl_in, .res_out, .zr_out, .ng_out
  );

  localparam logic [5:0] CODES [18] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101
  };

  function automatic logic [W-1:0] ref_fn(int k, logic [W-1:0] x, logic [W-1:0] y);
    case (k)
      0:  return '0;
      1:  return W'(1);
      2:  return '1;
      3:  return x;
      4:  return y;
      5:  return ~x;
      6:  return ~y;
      7:  return W'(0 - x);
      8:  return W'(0 - y);
      9:  return W'(x + 1);
      10: return W'(y + 1);
      11: return W'(x - 1);
      12: return W'(y - 1);
      13: return W'(x + y);
      14: return W'(x - y);
      15: return W'(y - x);
      16: return x & y;
      default: return x | y;
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [5:0] c, input logic [W-1:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    x_in   = x;
    y_in   = y;
    ctl_in = c;
    it.res = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: one item per edge, sampled a quarter period after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_T/4);
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (res_out !== it.res) begin
          n_bad++;
          $display("FAIL %s result: got %h expected %h", it.tag, res_out, it.res);
        end
        n_chk++;
        if (zr_out !== (it.res == '0)) begin
          n_bad++;
          $display("FAIL R7 %s zero flag: got %b expected %b", it.tag, zr_out, it.res == '0);
        end
        n_chk++;
        if (ng_out !== it.res[W-1]) begin
          n_bad++;
          $display("FAIL R8 %s negative flag: got %b expected %b", it.tag, ng_out, it.res[W-1]);
        end
      end
    end
  end

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corner [4];
    corner[0] = '0;
    corner[1] = {1'b0, {(W-1){1'b1}}};
    corner[2] = {1'b1, {(W-1){1'b0}}};
    corner[3] = '1;

    // R9: reset state, with non-zero inputs present during reset
    x_in   = 16'h1234;
    y_in   = 16'h5678;
    ctl_in = 6'b000010;
    repeat (3) @(posedge clk);
    #(CLK_T/4);
    n_chk++;
    if (res_out !== '0 || zr_out !== 1'b1 || ng_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: got %h/%b/%b expected 0000/1/0", res_out, zr_out, ng_out);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1: clear-x wins over a non-zero x; with sum this yields y
    apply(16'hABCD, 16'h0042, 6'b100010, 16'h0042, "R1 clear-x");
    // R2: flip-x alone under AND with y all ones gives ~x
    apply(16'h0F0F, 16'hFFFF, 6'b010000, 16'hF0F0, "R2 flip-x");
    // R3: clear-y and flip-y; clear-y then sum gives x, both give x-1
    apply(16'h0100, 16'h7777, 6'b001010, 16'h0100, "R3 clear-y");
    apply(16'h0100, 16'h7777, 6'b001110, 16'h00FF, "R3 clear-flip-y");
    // R4: carry out is dropped
    apply(16'hFFFF, 16'h0002, 6'b000010, 16'h0001, "R4 carry drop");
    apply(16'h7FFF, 16'h0001, 6'b000010, 16'h8000, "R4 sign wrap");
    // R5: bitwise AND
    apply(16'hF0CC, 16'h3CAA, 6'b000000, 16'h3088, "R5 and");
    // R6: flip-out complements AND
    apply(16'hF0CC, 16'h3CAA, 6'b000001, 16'hCF77, "R6 flip-out");

    // R10: every canonical code on corner operands, then on random ones
    for (int k = 0; k < 18; k++) begin
      for (int a = 0; a < 4; a++) begin
        apply(corner[a], corner[3-a], CODES[k], ref_fn(k, corner[a], corner[3-a]), "R10 corner");
      end
    end
    for (int r = 0; r < N_RAND; r++) begin
      for (int k = 0; k < 18; k++) begin
        logic [W-1:0] xv;
        logic [W-1:0] yv;
        xv = W'($urandom);
        yv = W'($urandom);
        apply(xv, yv, CODES[k], ref_fn(k, xv, yv), "R10 random");
      end
    end

    // R9: reset mid-stream clears the output again
    @(negedge clk);
    x_in   = 16'h8001;
    y_in   = 16'h8001;
    ctl_in = 6'b000010;
    rst    = 1'b1;
    @(posedge clk);
    #(CLK_T/4);
    n_chk++;
    if (res_out !== '0 || zr_out !== 1'b1 || ng_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 re-reset: got %h/%b/%b expected 0000/1/0", res_out, zr_out, ng_out);
    end
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule